// File: doc/BRIEF.md
# Load-Use Stall Controller

This controller sits beside the decode stage of a five-stage in-order pipeline. Each cycle it looks at two raw 32-bit instruction words: the one latched in the fetch/decode register and the one latched in the decode/execute register. If the older instruction is a memory read whose result a bypass network cannot supply in time, the younger one must wait. When that happens the controller holds the program counter and the fetch/decode register for one cycle and tells the decode/execute register to take a bubble, so every control field there is zero.

It works from the instruction words alone. The opcode sits in bits 31:26, the first source register in bits 25:21 and the second in bits 20:16. A memory read writes the register named in bits 20:16. The younger instruction's opcode decides which of its two register fields it actually reads.

A two-state machine handles the cycle after a stall. After a stall, the decode/execute register still holds the old read's word, but its control is a bubble. In state STALL that word is therefore treated as empty. The machine has two states: FLOW, where hazards are evaluated, and STALL, the single cycle after a stall. It has three transitions: HIT (FLOW to STALL when a hazard is seen), KEEP (FLOW to FLOW when none is seen) and RESUME (STALL to FLOW, always taken).

Top module: `load_use_hazard_unit`

## Requirements
- R1: The older instruction counts as a memory read when bits 31:26 equal 0x20, 0x21, 0x23, 0x24 or 0x25; any of these can raise a hazard.
- R2: In state FLOW, a stall is raised when the read's bits 20:16 equal the younger instruction's bits 25:21 and the younger opcode reads that field. The opcodes that read it are 0x00, 0x04, 0x05, 0x08 to 0x0E, the read opcodes of R1, and 0x28, 0x29, 0x2B.
- R3: In state FLOW, a stall is also raised when the read's bits 20:16 equal the younger instruction's bits 20:16 and the younger opcode is 0x00, 0x04, 0x05, 0x28, 0x29 or 0x2B.
- R4: A younger immediate-ALU instruction (0x08 to 0x0E) or memory read never stalls on a match in bits 20:16 alone, because there that field names a destination.
- R5: A memory read whose bits 20:16 are zero never raises a stall.
- R6: An older instruction that is not a memory read never raises a stall.
- R7: While a stall is raised, pc_write and ifid_write are 0 and idex_bubble is 1 in that same cycle. Otherwise the outputs are 1, 1 and 0.
- R8: A stall lasts exactly one cycle. In the cycle after it (state STALL), the older word is treated as a bubble and no stall is raised, even if the inputs are unchanged.
- R9: Two dependent memory reads in a row each cause one stall. The second is evaluated afresh once it reaches the decode/execute register.
- R10: While rst_n is low, no stall is raised and the state is FLOW. The first cycle after release evaluates hazards normally.
- R11: A younger jump (0x02, 0x03) or upper-immediate load (0x0F) never stalls, whatever its register fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_instr | input | 32 | Instruction word in the fetch/decode register |
| idex_instr | input | 32 | Instruction word in the decode/execute register |
| pc_write | output | 1 | Program counter update enable (0 holds it) |
| ifid_write | output | 1 | Fetch/decode register update enable (0 holds it) |
| idex_bubble | output | 1 | Selects zeroed control into the decode/execute register |

## Verification
Every cycle, the assertions check several things: the three strobes agree with one another, a stall is never followed by a second one, a zero destination or a non-read older instruction stays quiet, a jump stays quiet, and a register-register source match in FLOW does stall. Other behaviour only shows up in the bench's scenarios. This covers the field each younger opcode reads, the memory-read opcode set, the masking of a stale word held for a second cycle, the back-to-back read chain, and behaviour across reset release.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int INSTR_W = 32;
    localparam int OP_W    = 6;
    localparam int REG_W   = 5;
    localparam int OP_HI   = INSTR_W - 1;
    localparam int OP_LO   = INSTR_W - OP_W;
    localparam int SA_HI   = OP_LO - 1;
    localparam int SA_LO   = OP_LO - REG_W;
    localparam int SB_HI   = SA_LO - 1;
    localparam int SB_LO   = SA_LO - REG_W;
    localparam int NUM_SRC = 2;

    typedef enum logic [0:0] {ST_FLOW, ST_STALL} hz_state_t;

    typedef struct packed {
        logic [NUM_SRC-1:0]            used;
        logic [NUM_SRC-1:0][REG_W-1:0] idx;
    } src_use_t;

    function automatic logic is_mem_read(input logic [OP_W-1:0] op);
        case (op)
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
    import hz_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output src_use_t           srcs
);
    logic [OP_W-1:0] op;
    logic            reads_a;
    logic            reads_b;
    logic            unused_tail;

    assign op          = instr[OP_HI:OP_LO];
    assign unused_tail = ^instr[SB_LO-1:0];

    always_comb begin
        reads_a = 1'b0;
        reads_b = 1'b0;
        case (op)
            6'h00, 6'h04, 6'h05, 6'h28, 6'h29, 6'h2B: begin
                reads_a = 1'b1;
                reads_b = 1'b1;
            end
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E,
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
                reads_a = 1'b1;
            end
            default: ;
        endcase
    end

    assign srcs.used = {reads_b, reads_a};
    assign srcs.idx  = {instr[SB_HI:SB_LO], instr[SA_HI:SA_LO]};
endmodule

// File: rtl/hz_load_probe.sv
module hz_load_probe
    import hz_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               live,
    output logic [REG_W-1:0]   dest
);
    logic unused_rest;

    assign unused_rest = ^{instr[SA_HI:SA_LO], instr[SB_LO-1:0]};
    assign dest        = instr[SB_HI:SB_LO];
    assign live        = is_mem_read(instr[OP_HI:OP_LO]) && (dest != '0);
endmodule

// File: rtl/hz_compare.sv
module hz_compare
    import hz_pkg::*;
(
    input  src_use_t         srcs,
    input  logic             live,
    input  logic [REG_W-1:0] dest,
    output logic             hit
);
    logic [NUM_SRC-1:0] match;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_port
        assign match[g] = srcs.used[g] && (srcs.idx[g] == dest);
    end

    assign hit = live && (|match);
endmodule

// File: rtl/load_use_hazard_unit.sv
module load_use_hazard_unit
    import hz_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] ifid_instr,
    input  logic [INSTR_W-1:0] idex_instr,
    output logic               pc_write,
    output logic               ifid_write,
    output logic               idex_bubble
);
    hz_state_t        state_q;
    hz_state_t        state_d;
    src_use_t         young_srcs;
    logic             old_live;
    logic [REG_W-1:0] old_dest;
    logic             raw_hit;

    hz_src_decode u_src (
        .instr (ifid_instr),
        .srcs  (young_srcs)
    );

    hz_load_probe u_probe (
        .instr (idex_instr),
        .live  (old_live),
        .dest  (old_dest)
    );

    hz_compare u_cmp (
        .srcs (young_srcs),
        .live (old_live),
        .dest (old_dest),
        .hit  (raw_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    // transitions: HIT, KEEP, RESUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW:  state_d = raw_hit ? ST_STALL : ST_FLOW;
            ST_STALL: state_d = ST_FLOW;
            default:  state_d = ST_FLOW;
        endcase
    end

    // outputs: older word is a bubble while in STALL
    always_comb begin
        pc_write    = 1'b1;
        ifid_write  = 1'b1;
        idex_bubble = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                if (raw_hit && rst_n) begin
                    pc_write    = 1'b0;
                    ifid_write  = 1'b0;
                    idex_bubble = 1'b1;
                end
            end
            ST_STALL: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/hz_checker.sv
module hz_checker
    import hz_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] ifid_instr,
    input logic [INSTR_W-1:0] idex_instr,
    input logic               pc_write,
    input logic               ifid_write,
    input logic               idex_bubble
);
    logic unused_bits;
    assign unused_bits = ^{ifid_instr[SB_LO-1:0], idex_instr[SA_HI:SA_LO], idex_instr[SB_LO-1:0]};

    logic old_read;
    assign old_read = is_mem_read(idex_instr[OP_HI:OP_LO]);

    p_strobes_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_write == ifid_write) && (idex_bubble == !pc_write));

    p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_write |=> pc_write);

    p_zero_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (old_read && idex_instr[SB_HI:SB_LO] == '0) |-> pc_write);

    p_nonread_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !old_read |-> pc_write);

    p_jump_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_instr[OP_HI:OP_LO] == 6'h02 || ifid_instr[OP_HI:OP_LO] == 6'h03) |-> pc_write);

    p_rr_src_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pc_write) && old_read && idex_instr[SB_HI:SB_LO] != '0 &&
         ifid_instr[OP_HI:OP_LO] == 6'h00 &&
         ifid_instr[SA_HI:SA_LO] == idex_instr[SB_HI:SB_LO]) |-> !pc_write);
endmodule

bind load_use_hazard_unit hz_checker u_chk (.*);

// File: tb/sim_load_use_hazard_unit.sv
`timescale 1ns/1ps
module sim_load_use_hazard_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ifid_instr = '0;
    logic [31:0] idex_instr = '0;
    logic        pc_write, ifid_write, idex_bubble;
    int          n_total = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    always #2.5 clk = ~clk;

    load_use_hazard_unit u0 (.*);

    function automatic logic [31:0] rr(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
        return {6'h00, a, b, d, 5'd0, 6'h20};
    endfunction
    function automatic logic [31:0] im(input logic [5:0] op, input logic [4:0] a, input logic [4:0] b);
        return {op, a, b, 16'h0004};
    endfunction

    typedef struct packed {
        logic [31:0] ifid;
        logic [31:0] idex;
        logic        stall;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{rr(5,6,7),        im(6'h23,1,5), 1'b1, 4'd2},  // R2 reg-reg first source
        '{rr(6,5,7),        im(6'h23,1,5), 1'b1, 4'd3},  // R3 reg-reg second source
        '{rr(6,7,8),        im(6'h23,1,5), 1'b0, 4'd2},  // R2 no match
        '{im(6'h08,5,9),    im(6'h23,1,5), 1'b1, 4'd2},  // R2 immediate ALU source
        '{im(6'h08,6,5),    im(6'h23,1,5), 1'b0, 4'd4},  // R4 immediate ALU dest
        '{im(6'h2B,6,5),    im(6'h23,1,5), 1'b1, 4'd3},  // R3 store data
        '{im(6'h04,6,5),    im(6'h23,1,5), 1'b1, 4'd3},  // R3 branch
        '{im(6'h23,5,9),    im(6'h23,1,5), 1'b1, 4'd2},  // R2 read base
        '{im(6'h23,6,5),    im(6'h23,1,5), 1'b0, 4'd4},  // R4 read dest
        '{rr(0,0,3),        im(6'h23,1,0), 1'b0, 4'd5},  // R5 zero dest
        '{rr(5,5,7),        rr(1,2,5),     1'b0, 4'd6},  // R6 reg-reg older
        '{rr(5,5,7),        im(6'h2B,1,5), 1'b0, 4'd6},  // R6 store older
        '{rr(5,6,7),        im(6'h20,1,5), 1'b1, 4'd1},  // R1 byte read
        '{rr(6,5,7),        im(6'h25,1,5), 1'b1, 4'd1},  // R1 unsigned half read
        '{{6'h02,5'd5,5'd5,16'h0}, im(6'h23,1,5), 1'b0, 4'd11}, // R11 jump
        '{im(6'h0F,5,5),    im(6'h23,1,5), 1'b0, 4'd11}  // R11 upper immediate
    };

    task automatic step(input logic [31:0] y, input logic [31:0] o);
        @(negedge clk);
        ifid_instr = y;
        idex_instr = o;
        #1;
    endtask

    task automatic expect_stall(input logic exp, input string tag);
        logic [2:0] got, want;
        got  = {pc_write, ifid_write, idex_bubble};
        want = exp ? 3'b001 : 3'b110;
        n_total++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: {pc_write,ifid_write,idex_bubble}=%b expected %b", tag, got, want);
        end
    endtask

    initial begin
        // R10: held in reset with a hazard at the inputs
        ifid_instr = rr(5, 6, 7);
        idex_instr = im(6'h23, 1, 5);
        repeat (3) @(posedge clk);
        #1;
        expect_stall(1'b0, "R10 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_stall(1'b1, "R10 first cycle after release");
        step('0, '0);

        // table walk, each vector followed by a neutral cycle (R7 on all)
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].ifid, VECS[i].idex);
            expect_stall(VECS[i].stall, $sformatf("R%0d/R7 vector %0d", VECS[i].req, i));
            step('0, '0);
        end
        step('0, '0);

        // R8: same hazard held three cycles
        step(rr(5, 6, 7), im(6'h23, 1, 5));
        expect_stall(1'b1, "R8 cycle 1");
        step(rr(5, 6, 7), im(6'h23, 1, 5));
        expect_stall(1'b0, "R8 cycle 2 masked");
        step(rr(5, 6, 7), im(6'h23, 1, 5));
        expect_stall(1'b1, "R8 cycle 3 fresh");
        step('0, '0);
        step('0, '0);

        // R9: read r1; read r2 via r1; add uses r2
        step(im(6'h23, 1, 2), im(6'h23, 4, 1));
        expect_stall(1'b1, "R9 first read stalls");
        step(im(6'h23, 1, 2), im(6'h23, 4, 1));
        expect_stall(1'b0, "R9 bubble cycle");
        step(rr(2, 4, 3), im(6'h23, 1, 2));
        expect_stall(1'b1, "R9 second read stalls");
        step(rr(2, 4, 3), im(6'h23, 1, 2));
        expect_stall(1'b0, "R9 second bubble");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule